// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This block watches a free-running 64-bit system count supplied from outside and compares it against a 64-bit deadline register. When the count reaches or passes the deadline while the block is armed, a warning output is raised. At the same moment the deadline moves forward by a 32-bit grace offset. If software still has not serviced the block when the count catches up again, a reset request is raised and held.

Software services the block through a small word-addressed register interface. It can refresh the block by writing to a dedicated refresh word with any data, or by writing the control word with the arm bit set. It can also rewrite either half of the deadline directly at any moment, which replaces the value the block computed itself. The total time from the last refresh to a reset request is therefore the first deadline distance plus the grace offset. Routing of the warning, generation of the actual reset and any bus adapter are outside this block.

Top module: `cmp_watchdog`

## Requirements
- R1: After reset, warn_o and rst_req_o are low, the control word reads 0, the offset reads 0 and both deadline halves read 0xFFFFFFFF.
- R2: Word map: 0 = control (bit 0 arm, bit 1 warning status, bit 2 reset-request status; only bit 0 is writable), 1 = grace offset, 2 = deadline bits 31:0, 3 = deadline bits 63:32, 4 = refresh. reg_rdata_o follows reg_addr_i combinationally.
- R3: While armed and warn_o is low, a cycle with sys_cnt_i >= deadline (unsigned) and no register write raises warn_o after that clock edge, and the deadline becomes that cycle's sys_cnt_i plus the zero-extended offset.
- R4: While armed and warn_o is high, a cycle with sys_cnt_i >= deadline raises rst_req_o after that edge; rst_req_o then stays high until a refresh, a control write or reset.
- R5: A write to word 4, whatever the data, clears warn_o and rst_req_o and loads the deadline with sys_cnt_i plus the offset.
- R6: A control write with bit 0 set arms the block and acts as a refresh in the same edge.
- R7: A control write with bit 0 clear disarms the block and clears warn_o and rst_req_o; while disarmed no expiry is evaluated, whatever sys_cnt_i is.
- R8: A write to a deadline half replaces that half at the edge, takes priority over an automatic reload of that half in the same cycle, and leaves warn_o as it is.
- R9: When a refresh and an expiry fall in the same cycle, the refresh wins: warn_o stays low and the deadline takes the refresh value.
- R10: rst_req_o is never high while warn_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_cnt_i | input | 64 | Free-running system count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address for write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| warn_o | output | 1 | First-stage warning |
| rst_req_o | output | 1 | Second-stage reset request |

## Verification
The expiry evaluation and a software write can land on the same clock edge, and the design must resolve them in a fixed order. The bench drives the system count to exactly the deadline in the very cycle it issues a refresh, and separately in the cycle it writes the low deadline half. It then judges the outcome at the ports: after the refresh the warning must stay low and the deadline must read back the refresh value. After the half write the warning must rise while the low half holds the written data instead of the reload.

// File: rtl/cmpwd_pkg.sv
package cmpwd_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned OFS_ADDR  = 1;
  localparam int unsigned CMP_BASE  = 2;
  localparam int unsigned ST_EN     = 0;
  localparam int unsigned ST_WARN   = 1;
  localparam int unsigned ST_RST    = 2;
endpackage

// File: rtl/cmpwd_regif.sv
module cmpwd_regif
  import cmpwd_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned OFS_W     = 32,
  parameter int unsigned CMP_WORDS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 en_o,
  output logic [OFS_W-1:0]     ofs_o,
  output logic                 kick_o,
  output logic                 ctrl_wr_o,
  output logic [CMP_WORDS-1:0] cmp_wr_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_OFS  = ADDR_W'(OFS_ADDR);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(CMP_BASE + CMP_WORDS);

  logic en_q;
  logic [OFS_W-1:0] ofs_q;

  assign ctrl_wr_o = we_i && (addr_i == A_CTRL);
  assign kick_o    = (we_i && (addr_i == A_KICK)) || (ctrl_wr_o && wdata_i[ST_EN]);

  for (genvar i = 0; i < CMP_WORDS; i++) begin : g_cmp_wr
    assign cmp_wr_o[i] = we_i && (addr_i == ADDR_W'(CMP_BASE + i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ofs_q <= '0;
    end else begin
      if (ctrl_wr_o) en_q <= wdata_i[ST_EN];
      if (we_i && (addr_i == A_OFS)) ofs_q <= wdata_i[OFS_W-1:0];
    end
  end

  assign en_o  = en_q;
  assign ofs_o = ofs_q;
endmodule

// File: rtl/cmpwd_cmp.sv
module cmpwd_cmp #(
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned OFS_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CMP_WORDS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     sys_cnt_i,
  input  logic [OFS_W-1:0]     ofs_i,
  input  logic                 reload_i,
  input  logic [CMP_WORDS-1:0] cmp_wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]     cmp_o,
  output logic                 expired_o
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] next_dl;

  assign next_dl = sys_cnt_i + {{(CNT_W-OFS_W){1'b0}}, ofs_i};

  // software half writes outrank the automatic reload, per word
  for (genvar i = 0; i < CMP_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmp_q[i*DATA_W +: DATA_W] <= '1;
      else if (cmp_wr_i[i]) cmp_q[i*DATA_W +: DATA_W] <= wdata_i;
      else if (reload_i)    cmp_q[i*DATA_W +: DATA_W] <= next_dl[i*DATA_W +: DATA_W];
    end
  end

  assign expired_o = (sys_cnt_i >= cmp_q);
  assign cmp_o     = cmp_q;
endmodule

// File: rtl/cmpwd_stage.sv
module cmpwd_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic expired_i,
  output logic arm_o,
  output logic ws0_o,
  output logic ws1_o
);
  logic ws0_q, ws1_q;
  logic hit;

  assign hit   = en_i && expired_i && !clr_i;
  assign arm_o = hit && !ws0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else if (hit) begin
      ws0_q <= 1'b1;
      if (ws0_q) ws1_q <= 1'b1;
    end
  end

  assign ws0_o = ws0_q;
  assign ws1_o = ws1_q;
endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog
  import cmpwd_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  sys_cnt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              warn_o,
  output logic              rst_req_o
);
  localparam int unsigned CMP_WORDS = CNT_W / DATA_W;

  logic                 en_q, kick, ctrl_wr, expired, arm;
  logic [OFS_W-1:0]     ofs_q;
  logic [CMP_WORDS-1:0] cmp_wr;
  logic [CNT_W-1:0]     cmp_q;

  cmpwd_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CMP_WORDS(CMP_WORDS)
  ) u_regif (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en_q), .ofs_o(ofs_q), .kick_o(kick), .ctrl_wr_o(ctrl_wr), .cmp_wr_o(cmp_wr)
  );

  cmpwd_cmp #(
    .CNT_W(CNT_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .CMP_WORDS(CMP_WORDS)
  ) u_cmp (
    .clk_i, .rst_ni, .sys_cnt_i, .ofs_i(ofs_q),
    .reload_i(kick || arm), .cmp_wr_i(cmp_wr), .wdata_i(reg_wdata_i),
    .cmp_o(cmp_q), .expired_o(expired)
  );

  cmpwd_stage u_stage (
    .clk_i, .rst_ni, .en_i(en_q), .clr_i(kick || ctrl_wr), .expired_i(expired),
    .arm_o(arm), .ws0_o(warn_o), .ws1_o(rst_req_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata_o[ST_EN]   = en_q;
      reg_rdata_o[ST_WARN] = warn_o;
      reg_rdata_o[ST_RST]  = rst_req_o;
    end else if (reg_addr_i == ADDR_W'(OFS_ADDR)) begin
      reg_rdata_o[OFS_W-1:0] = ofs_q;
    end
    for (int i = 0; i < CMP_WORDS; i++) begin
      if (reg_addr_i == ADDR_W'(CMP_BASE + i)) reg_rdata_o = cmp_q[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cmpwd_chk.sv
module cmpwd_chk #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  sys_cnt_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              ctrl_bit_i,
  input logic              warn_o,
  input logic              rst_req_o,
  input logic              en_q,
  input logic [CNT_W-1:0]  cmp_q
);
  logic ctrl_wr, kick_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_W'(0));
  assign kick_wr = reg_we_i && (reg_addr_i == ADDR_W'(4));

  assert_rst_implies_warn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> warn_o);

  assert_warn_on_expiry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !warn_o && (sys_cnt_i >= cmp_q) && !reg_we_i) |=> warn_o);

  assert_rst_after_warn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && warn_o && (sys_cnt_i >= cmp_q) && !reg_we_i) |=> rst_req_o);

  assert_rst_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !ctrl_wr && !kick_wr) |=> rst_req_o);

  assert_refresh_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_wr |=> (!warn_o && !rst_req_o));

  assert_disarm_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !ctrl_bit_i) |=> (!warn_o && !rst_req_o && !en_q));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ctrl_wr) |=> (!warn_o && !rst_req_o));
endmodule

bind cmp_watchdog cmpwd_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_cnt_i(sys_cnt_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .ctrl_bit_i(reg_wdata_i[0]), .warn_o(warn_o),
  .rst_req_o(rst_req_o), .en_q(en_q), .cmp_q(cmp_q)
);

// File: tb/cmp_watchdog_bench.sv
module cmp_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_cnt = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        warn, rst_req;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  cmp_watchdog u_cmp_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .sys_cnt_i(sys_cnt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .warn_o(warn), .rst_req_o(rst_req)
  );

  // {start count, offset}
  localparam logic [95:0] VEC [4] = '{
    {64'd100,                   32'd10},
    {64'h0000_0000_FFFF_FFF0,   32'h20},
    {64'h0000_0001_0000_0000,   32'hFFFF_FFFF},
    {64'd0,                     32'd1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_cmp(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'd2, lo); rd(3'd3, hi);
    v = {hi, lo};
  endtask

  initial begin
    #4000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c;
    #25; rst_n = 1'b1; step();

    // R1 reset state
    check("R1 warn", 64'(warn), 0);
    check("R1 rst_req", 64'(rst_req), 0);
    rd(3'd0, r); check("R1 ctrl", 64'(r), 0);
    rd(3'd1, r); check("R1 offset", 64'(r), 0);
    rd_cmp(c); check("R1 deadline", c, 64'hFFFF_FFFF_FFFF_FFFF);

    // table walk: arm-refresh, approach, first expiry (R3, R6)
    for (int i = 0; i < 4; i++) begin
      logic [63:0] s, dl;
      logic [31:0] o;
      s = VEC[i][95:32]; o = VEC[i][31:0];
      wr(3'd0, 32'd0);
      wr(3'd1, o);
      sys_cnt = s;
      wr(3'd0, 32'd1);
      dl = s + 64'(o);
      rd_cmp(c); check("R6 arm reload", c, dl);
      rd(3'd1, r); check("R2 offset readback", 64'(r), 64'(o));
      sys_cnt = dl - 64'd1; step();
      check("R3 before deadline", 64'(warn), 0);
      sys_cnt = dl; step();
      check("R3 at deadline", 64'(warn), 1);
      rd_cmp(c); check("R3 rearm", c, dl + 64'(o));
    end

    // escalation to reset request, R4
    wr(3'd0, 32'd0); wr(3'd1, 32'd10);
    sys_cnt = 64'd100; wr(3'd0, 32'd1);
    sys_cnt = 64'd110; step();
    check("R3 warn", 64'(warn), 1);
    sys_cnt = 64'd119; step();
    check("R4 early", 64'(rst_req), 0);
    sys_cnt = 64'd120; step();
    check("R4 escalate", 64'(rst_req), 1);
    sys_cnt = 64'd500; step(); step();
    check("R4 sticky", 64'(rst_req), 1);
    rd(3'd0, r); check("R2 ctrl status", 64'(r), 64'd7);
    check("R10 warn with rst_req", 64'(warn), 1);

    // disarm during stage 1, R7
    wr(3'd0, 32'd0);
    check("R7 warn cleared", 64'(warn), 0);
    check("R7 rst_req cleared", 64'(rst_req), 0);
    rd(3'd0, r); check("R7 ctrl", 64'(r), 0);
    sys_cnt = 64'hFFFF_FFFF_0000_0000; step(); step();
    check("R7 no expiry disarmed", 64'(warn), 0);

    // refresh before expiry, R5
    sys_cnt = 64'd1000; wr(3'd0, 32'd1);
    sys_cnt = 64'd1009; wr(3'd4, 32'hDEAD_BEEF);
    rd_cmp(c); check("R5 refresh reload", c, 64'd1019);
    sys_cnt = 64'd1015; step();
    check("R5 no warn", 64'(warn), 0);

    // direct overwrite after warning, R8
    sys_cnt = 64'd1019; step();
    check("R3 warn 2", 64'(warn), 1);
    wr(3'd2, 32'd5000); wr(3'd3, 32'd0);
    rd_cmp(c); check("R8 overwrite", c, 64'd5000);
    check("R8 warn kept", 64'(warn), 1);
    sys_cnt = 64'd1029; step();
    check("R8 old deadline ignored", 64'(rst_req), 0);
    sys_cnt = 64'd5000; step();
    check("R8 new deadline", 64'(rst_req), 1);

    // refresh and expiry same cycle, R9
    sys_cnt = 64'd6000; wr(3'd0, 32'd1);
    sys_cnt = 64'd6010; wr(3'd4, 32'd0);
    check("R9 warn low", 64'(warn), 0);
    rd_cmp(c); check("R9 refresh value", c, 64'd6020);

    // half write in the expiry cycle, R8
    sys_cnt = 64'd6020; wr(3'd2, 32'd7000);
    check("R8 warn rises", 64'(warn), 1);
    rd_cmp(c); check("R8 half wins", c, 64'd7000);

    // reset mid-operation returns to R1 state
    rst_n = 1'b0; #5; rst_n = 1'b1; step();
    check("R1 after reset", 64'(warn), 0);
    rd(3'd0, r); check("R1 ctrl after reset", 64'(r), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule